// File: doc/BRIEF.md
# Two-Phase Sub-Cycle PWM Generator

This block drives a pair of power-stage switches from one 12-bit timebase. Every PWM cycle has two halves that run one after the other. In sub-cycle A only output A may be active. In sub-cycle B only output B may be active. Each half compares the running count against its own duty value. The counter either ramps up and wraps to zero, or it ramps up and then back down. A mode select input picks the counting style.

Software writes the top value and the two duty values through a small write port. The written values wait in holding registers. They move into the working set only when sub-cycle B finishes, so a PWM cycle never runs with a mix of old and new settings. A one-clock cycle-end pulse marks that hand-over.

A protection input blanks both outputs combinationally, with no clock edge needed. The block also latches the fault, and the latched fault keeps the outputs low until software requests a clear. That request is honoured only at a cycle boundary.

Top module: `pwm2_subcycle_gen`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) sets the following to zero: the counter, all working and holding settings, and the fault latch. After reset the block is in sub-cycle A and in single-ramp mode, and out_a, out_b and cycle_end are low.
- R2: Single-ramp mode (working mode bit 0): the counter steps by one per clock from 0 to the working top value T. It returns to 0 on the clock after T. Each sub-cycle lasts T+1 clocks, and sub-cycle A and sub-cycle B alternate.
- R3: Centered mode (working mode bit 1): the counter climbs 0,1,…,T and then falls T-1,…,1. The next sub-cycle then starts from 0, so each sub-cycle lasts 2·T clocks. For T=1 the sequence is 0,1.
- R4: out_a is high exactly when the block is in sub-cycle A, T≠0, the count is below the working duty A, and there is no fault. out_b obeys the same rule with sub-cycle B and duty B. The two outputs are never high together.
- R5: A write with wr_addr 0 (top), 1 (duty A) or 2 (duty B) only updates a holding register. The working value changes on the clock edge that ends sub-cycle B. A write presented during that last clock itself waits for the following boundary.
- R6: The mode_centered input is copied into the working mode only at a cycle boundary. A change in the middle of a cycle does not alter the counting of that cycle.
- R7: cycle_end is high for exactly the last clock of sub-cycle B while T≠0. On the clock edge that ends it, the holding registers load into the working set and the counter restarts at 0 in sub-cycle A.
- R8: While fault_in is high, out_a and out_b are low in the same instant, without waiting for a clock edge.
- R9: fault_in seen high at a clock edge sets a fault latch that holds both outputs low. A write with wr_addr 3 requests a clear. The latch drops at the next cycle boundary unless fault_in is high at that edge.
- R10: While the working top is 0, the following hold: the counter stays at 0, both outputs stay low, and cycle_end stays low. Every clock counts as a boundary, so the holding registers, the mode and a pending clear take effect on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the setting port |
| wr_addr | input | 2 | 0 top, 1 duty A, 2 duty B, 3 fault clear request |
| wr_data | input | 12 | Write data |
| mode_centered | input | 1 | 0 single-ramp, 1 centered; applied at a boundary |
| fault_in | input | 1 | Protection input, active high |
| out_a | output | 1 | PWM output owned by sub-cycle A |
| out_b | output | 1 | PWM output owned by sub-cycle B |
| cycle_end | output | 1 | High during the last clock of sub-cycle B |
| count | output | 12 | Current counter value |

## Verification
Two pairs of events can fall on the same clock. A setting write can land on the clock where the boundary also loads the working set. A fault clear can be due at a boundary while fault_in is still high. The bench provokes the first by waiting for cycle_end and writing in that very clock. It provokes the second by holding fault_in across a pending clear. A behavioural model judges both clock by clock: the late write must wait for the next boundary, and the fault must win over the clear.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;

    localparam int CNT_W  = 12;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] SEL_TOP  = 2'd0;
    localparam logic [ADDR_W-1:0] SEL_DUTA = 2'd1;
    localparam logic [ADDR_W-1:0] SEL_DUTB = 2'd2;
    localparam logic [ADDR_W-1:0] SEL_CLR  = 2'd3;

    typedef enum logic {SUB_A = 1'b0, SUB_B = 1'b1} sub_e;
    typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} dir_e;

    typedef struct packed {
        logic             centered;
        logic [CNT_W-1:0] top;
        logic [CNT_W-1:0] duty_a;
        logic [CNT_W-1:0] duty_b;
    } cfg_t;

    // last clock of a sub-cycle for the given working settings
    function automatic logic sub_last(input cfg_t c, input logic [CNT_W-1:0] cnt,
                                      input dir_e dir);
        logic [CNT_W-1:0] one;
        one = {{(CNT_W-1){1'b0}}, 1'b1};
        if (c.centered)
            return ((dir == DIR_DN) && (cnt == one)) ||
                   ((dir == DIR_UP) && (cnt == c.top) && (c.top == one));
        else
            return cnt == c.top;
    endfunction

endpackage

// File: rtl/pwm2_regs.sv
module pwm2_regs
    import pwm2_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              mode_in,
    input  logic              bnd,
    output cfg_t              act,
    output logic              clr_req
);

    cfg_t shd;

    always_ff @(posedge clk) begin
        if (rst) begin
            shd     <= '0;
            act     <= '0;
            clr_req <= 1'b0;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    SEL_TOP:  shd.top    <= wr_data;
                    SEL_DUTA: shd.duty_a <= wr_data;
                    SEL_DUTB: shd.duty_b <= wr_data;
                    default:  ;
                endcase
            end
            if (bnd) begin
                act.centered <= mode_in;
                act.top      <= shd.top;
                act.duty_a   <= shd.duty_a;
                act.duty_b   <= shd.duty_b;
            end
            if (wr_en && wr_addr == SEL_CLR)
                clr_req <= 1'b1;
            else if (bnd)
                clr_req <= 1'b0;
        end
    end

    assert_hold_between_R5: assert property (@(posedge clk) disable iff (rst)
        !bnd |=> $stable(act));

    assert_mode_held_R6: assert property (@(posedge clk) disable iff (rst)
        (!bnd && mode_in != act.centered) |=> $stable(act.centered));

endmodule

// File: rtl/pwm2_timebase.sv
module pwm2_timebase
    import pwm2_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cfg_t             act,
    output logic [CNT_W-1:0] cnt,
    output sub_e             sub,
    output logic             cyc_last,
    output logic             bnd
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    dir_e dir;
    logic idle;
    logic last;

    assign idle     = (act.top == '0);
    assign last     = sub_last(act, cnt, dir);
    assign cyc_last = !idle && (sub == SUB_B) && last;
    assign bnd      = idle || cyc_last;

    always_ff @(posedge clk) begin
        if (rst || idle) begin
            cnt <= '0;
            sub <= SUB_A;
            dir <= DIR_UP;
        end else if (last) begin
            cnt <= '0;
            dir <= DIR_UP;
            sub <= (sub == SUB_A) ? SUB_B : SUB_A;
        end else if (act.centered && dir == DIR_UP && cnt == act.top) begin
            cnt <= act.top - ONE;
            dir <= DIR_DN;
        end else if (dir == DIR_DN) begin
            cnt <= cnt - ONE;
        end else begin
            cnt <= cnt + ONE;
        end
    end

    assert_cnt_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= act.top);

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
        idle |=> (cnt == '0 && sub == SUB_A));

    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        cyc_last |=> (cnt == '0 && sub == SUB_A));

    assert_centered_turn_R3: assert property (@(posedge clk) disable iff (rst)
        (act.centered && dir == DIR_UP && cnt == act.top && act.top > ONE)
            |=> cnt == $past(act.top) - ONE);

endmodule

// File: rtl/pwm2_guard.sv
module pwm2_guard (
    input  logic clk,
    input  logic rst,
    input  logic fault_in,
    input  logic clr_req,
    input  logic bnd,
    input  logic raw_a,
    input  logic raw_b,
    output logic out_a,
    output logic out_b
);

    logic held;

    always_ff @(posedge clk) begin
        if (rst)
            held <= 1'b0;
        else if (fault_in)
            held <= 1'b1;
        else if (bnd && clr_req)
            held <= 1'b0;
    end

    // protection path is combinational so no clock edge is needed
    assign out_a = raw_a && !fault_in && !held;
    assign out_b = raw_b && !fault_in && !held;

    assert_fault_blanks_R8: assert property (@(posedge clk) disable iff (rst)
        fault_in |-> (!out_a && !out_b));

    assert_fault_latches_R9: assert property (@(posedge clk) disable iff (rst)
        fault_in |=> (!out_a && !out_b && held));

endmodule

// File: rtl/pwm2_subcycle_gen.sv
module pwm2_subcycle_gen
    import pwm2_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              mode_centered,
    input  logic              fault_in,
    output logic              out_a,
    output logic              out_b,
    output logic              cycle_end,
    output logic [CNT_W-1:0]  count
);

    cfg_t act;
    logic clr_req;
    logic bnd;
    sub_e sub;
    logic raw_a;
    logic raw_b;
    logic running;

    pwm2_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mode_in (mode_centered),
        .bnd     (bnd),
        .act     (act),
        .clr_req (clr_req)
    );

    pwm2_timebase u_tb (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .cnt      (count),
        .sub      (sub),
        .cyc_last (cycle_end),
        .bnd      (bnd)
    );

    assign running = (act.top != '0);
    assign raw_a   = running && (sub == SUB_A) && (count < act.duty_a);
    assign raw_b   = running && (sub == SUB_B) && (count < act.duty_b);

    pwm2_guard u_guard (
        .clk      (clk),
        .rst      (rst),
        .fault_in (fault_in),
        .clr_req  (clr_req),
        .bnd      (bnd),
        .raw_a    (raw_a),
        .raw_b    (raw_b),
        .out_a    (out_a),
        .out_b    (out_b)
    );

    assert_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(out_a && out_b));

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        cycle_end |=> !cycle_end);

endmodule

// File: tb/pwm2_subcycle_gen_test.sv
module pwm2_subcycle_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [11:0] wr_data = 12'd0;
    logic        mode_centered = 1'b0;
    logic        fault_in = 1'b0;
    logic        out_a, out_b, cycle_end;
    logic [11:0] count;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pwm2_subcycle_gen uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mode_centered(mode_centered), .fault_in(fault_in),
        .out_a(out_a), .out_b(out_b), .cycle_end(cycle_end), .count(count)
    );

    // behavioural reference state
    int m_cnt, m_top, m_da, m_db, s_top, s_da, s_db;
    bit m_phb, m_down, m_cen, m_flt, m_clr;

    function automatic bit m_last();
        if (m_cen) return (m_down && m_cnt == 1) || (!m_down && m_cnt == m_top && m_top == 1);
        return m_cnt == m_top;
    endfunction

    always @(posedge clk) begin : model
        bit idle, lst, bnd;
        if (rst) begin
            m_cnt = 0; m_top = 0; m_da = 0; m_db = 0;
            s_top = 0; s_da = 0; s_db = 0;
            m_phb = 0; m_down = 0; m_cen = 0; m_flt = 0; m_clr = 0;
        end else begin
            idle = (m_top == 0);
            lst  = m_last();
            bnd  = idle || (m_phb && lst);
            if (idle) begin
                m_cnt = 0; m_phb = 0; m_down = 0;
            end else if (lst) begin
                m_cnt = 0; m_down = 0; m_phb = !m_phb;
            end else if (m_cen && !m_down && m_cnt == m_top) begin
                m_cnt = m_top - 1; m_down = 1;
            end else if (m_down) m_cnt = m_cnt - 1;
            else m_cnt = m_cnt + 1;
            if (fault_in) m_flt = 1;
            else if (bnd && m_clr) m_flt = 0;
            if (bnd) begin
                m_top = s_top; m_da = s_da; m_db = s_db; m_cen = mode_centered;
            end
            if (wr_en && wr_addr == 2'd3) m_clr = 1;
            else if (bnd) m_clr = 0;
            if (wr_en && wr_addr == 2'd0) s_top = wr_data;
            if (wr_en && wr_addr == 2'd1) s_da = wr_data;
            if (wr_en && wr_addr == 2'd2) s_db = wr_data;
        end
    end

    task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act_v, exp_v, $time);
        end
    endtask

    function automatic string out_req();
        if (fault_in) return "R8";
        if (m_flt) return "R9";
        if (m_top == 0) return "R10";
        return "R4";
    endfunction

    task automatic compare();
        bit blk;
        int ea, eb, ec;
        blk = fault_in || m_flt;
        ea = (!blk && m_top != 0 && !m_phb && m_cnt < m_da) ? 1 : 0;
        eb = (!blk && m_top != 0 && m_phb && m_cnt < m_db) ? 1 : 0;
        ec = (m_top != 0 && m_phb && m_last()) ? 1 : 0;
        check(count == m_cnt, m_cen ? "R3 count" : "R2 count", count, m_cnt);
        check(out_a == ea, out_req(), out_a, ea);
        check(out_b == eb, out_req(), out_b, eb);
        check(cycle_end == ec, "R7 cycle_end", cycle_end, ec);
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        compare();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        wr_en = 1; wr_addr = a; wr_data = d[11:0];
        tick();
        wr_en = 0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 200 && !cycle_end; i++) tick();
    endtask

    initial begin
        run(3);
        rst = 0;
        #1;
        // R1: reset state
        check(count == 0 && !out_a && !out_b && !cycle_end, "R1 reset", count, 0);
        run(4);
        // R10: idle with top zero
        check(count == 0 && !out_a && !out_b, "R10 idle", count, 0);

        // single-ramp operation
        wr(2'd1, 3);
        wr(2'd2, 2);
        wr(2'd0, 5);
        run(30);

        // R5: mid-cycle top change deferred to boundary
        run(2);
        wr(2'd0, 7);
        wr(2'd1, 6);
        wait_end();
        check(count == 5, "R5 old top kept", count, 5);
        tick();
        run(7);
        check(count == 7, "R5 new top applied", count, 7);

        // R5: write landing on the boundary clock waits one more cycle
        wait_end();
        wr(2'd2, 1);
        wait_end();
        tick();
        run(20);

        // R6: mode change mid-cycle, applied at boundary; R3 counting
        run(3);
        mode_centered = 1;
        wait_end();
        check(count == 7, "R6 ramp until boundary", count, 7);
        tick();
        run(8);
        check(count == 6, "R3 centered turn", count, 6);
        run(40);
        wr(2'd0, 1);
        run(20);
        wr(2'd0, 4);
        run(30);

        // R8: immediate blanking between edges
        wait_end();
        tick();
        #1;
        fault_in = 1;
        #1;
        check(!out_a && !out_b, "R8 immediate", out_a | out_b, 0);
        run(3);
        fault_in = 0;
        run(10);
        // R9: clear requested while fault still high at boundary
        wr(2'd3, 0);
        fault_in = 1;
        wait_end();
        tick();
        fault_in = 0;
        run(20);
        check(!out_a && !out_b || m_flt == 0, "R9 fault wins clear", m_flt, 1);
        wr(2'd3, 0);
        wait_end();
        tick();
        run(30);

        // back to single ramp, then idle
        mode_centered = 0;
        run(30);
        wr(2'd0, 0);
        wait_end();
        run(5);
        check(count == 0 && !out_a && !out_b && !cycle_end, "R10 idle again", count, 0);
        wr(2'd0, 3);
        run(12);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule